// File: doc/BRIEF.md
# Secure-Gated Peripheral Access Gate

This block stands between a simple register bus and a set of peripheral register groups. It keeps an 8-bit access-enable register and a flag that says whether the bus master is running secure or non-secure code. For each bus access it decodes the target group from the upper address bits. In secure mode every access is let through. In non-secure mode an access goes through only when that group's enable bit is set. Blocked accesses are dropped: a blocked write is never forwarded, and a blocked read returns zero. Either kind raises a one-cycle violation pulse.

The enable register is asymmetric. Secure code may write any value to it. Non-secure code may only clear bits, so a right it gives up stays lost until secure code grants it again. Secure mode is entered through a dedicated entry pulse, which stands in for the trap sequence. It is left by writing the mode register with the secure flag clear. The gate only filters new bus accesses and sends no abort toward a peripheral. Revoking a right therefore leaves any operation already running in that group untouched.

Top module: `secure_access_gate`

## Requirements
- R1: After reset the block is in secure mode, the access register reads 0, and the mode register reads 0x0000_0001.
- R2: In secure mode, a write to the access register (group code 8, offset 0x00) stores the low 8 bits of the write data exactly as written.
- R3: The mode register is at group code 8, offset 0x04. Its bit 0 is the secure flag. A secure write with bit 0 clear leaves secure mode. Bits 1 and 6 of any write are kept and read back, and all other written bits read as 0. A non-secure write with bit 0 set does not enter secure mode.
- R4: In non-secure mode, a write to the access register stores the old value ANDed with the write data, so no bit can go from 0 to 1.
- R5: In non-secure mode, an access to group g (address bits [11:8] = g, for g in 0..7) whose enable bit g is 0 drives no grant and no forwarded write. A blocked read returns 0. The group's contents stay as they were before the blocked write.
- R6: In non-secure mode, an access to a group whose enable bit is 1 asserts that group's grant bit. A write also asserts the forwarded write enable, and a later read returns the data that was written.
- R7: Each blocked access raises `viol` in the cycle after the access edge, for exactly one cycle.
- R8: Accesses to the control page (the access register and the mode register) are allowed in both modes and never raise `viol`. The access register can be read in both modes.
- R9: A `sec_enter` pulse puts the block in secure mode from the next cycle. In secure mode all eight groups are granted, whatever the access register holds.
- R10: Grant bits are asserted only during a bus access. Clearing a group's enable bit sends nothing to that group, so data held there stays intact.
- R11: When `sec_enter` falls in the same cycle as a write to the access register, the write is judged under the mode in force before entry. When `sec_enter` falls in the same cycle as an exit write to the mode register, the block stays secure.
- R12: Accesses with group codes 9 to 15 grant nothing, raise no violation, and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Byte address; bits [11:8] select the group code |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, combinational in the strobe cycle |
| per_rdata | input | 32 | Read data returned by the granted peripheral group |
| sec_enter | input | 1 | Secure-entry pulse |
| grant | output | 8 | Per-group access grant, one-hot or zero |
| fwd_we | output | 1 | Write enable forwarded to the granted group |
| secure_o | output | 1 | Current secure-mode flag |
| viol | output | 1 | One-cycle pulse after a blocked access |

## Verification
Two functions can act in the same cycle: the secure-entry pulse, and a bus write to the control page. The bench drives `sec_enter` in the same cycle as a non-secure write of all ones to the access register. It then reads the register back and expects the old value unchanged, because the write was judged as non-secure. In a second case the bench drives the entry pulse together with an exit write to the mode register and expects `secure_o` to stay high.

// File: rtl/gate_pkg.sv
package gate_pkg;

   // Position of each enable bit in the access register (also the group code)
   typedef enum logic [2:0] {
      GRP_ERR   = 3'd0,
      GRP_IO    = 3'd1,
      GRP_GPIO  = 3'd2,
      GRP_BDMA  = 3'd3,
      GRP_CRYPT = 3'd4,
      GRP_XLAT  = 3'd5,
      GRP_FLASH = 3'd6,
      GRP_BUF   = 3'd7
   } grp_id_e;

   // Control page hits produced by the address decoder
   typedef struct packed {
      logic page;
      logic acc;
      logic mode;
   } ctrl_hit_t;

endpackage

// File: rtl/gate_decode.sv
module gate_decode
   import gate_pkg::*;
#(
   parameter int AW        = 12,
   parameter int SEL_W     = 4,
   parameter int NGRP      = 8,
   parameter int CTRL_CODE = 8,
   parameter int ACC_OFS   = 0,
   parameter int MODE_OFS  = 4
) (
   input  logic [AW-1:0]   addr,
   output logic [NGRP-1:0] grp_hit,
   output ctrl_hit_t       ctrl
);
   localparam int OFS_W = AW - SEL_W;

   logic [SEL_W-1:0] code;
   logic [OFS_W-1:0] ofs;

   assign code = addr[AW-1 -: SEL_W];
   assign ofs  = addr[OFS_W-1:0];

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      assign grp_hit[g] = (code == SEL_W'(g));
   end

   assign ctrl.page = (code == SEL_W'(CTRL_CODE));
   assign ctrl.acc  = ctrl.page && (ofs == OFS_W'(ACC_OFS));
   assign ctrl.mode = ctrl.page && (ofs == OFS_W'(MODE_OFS));

endmodule

// File: rtl/gate_acc_reg.sv
module gate_acc_reg #(
   parameter int NGRP = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr,
   input  logic [NGRP-1:0] wdata,
   input  logic            secure,
   output logic [NGRP-1:0] acc_q
);
   logic [NGRP-1:0] nxt;

   // Secure code writes freely; non-secure code can only drop rights
   always_comb begin
      nxt = acc_q;
      if (wr) nxt = secure ? wdata : (acc_q & wdata);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc_q <= '0;
      else        acc_q <= nxt;
   end

endmodule

// File: rtl/gate_mode_ctl.sv
module gate_mode_ctl #(
   parameter int          DW        = 32,
   parameter logic [31:0] KEEP_MASK = 32'h0000_0042
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sec_enter,
   input  logic          wr,
   input  logic [DW-1:0] wdata,
   output logic          secure,
   output logic [DW-1:0] mode_rd
);
   localparam logic [DW-1:0] KEEP = KEEP_MASK[DW-1:0];

   logic          secure_q;
   logic [DW-1:0] keep_q;

   // Entry pulse dominates; only secure code can leave secure mode
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         secure_q <= 1'b1;
         keep_q   <= '0;
      end else begin
         if (sec_enter)                      secure_q <= 1'b1;
         else if (wr && secure_q && !wdata[0]) secure_q <= 1'b0;
         if (wr) keep_q <= wdata & KEEP;
      end
   end

   assign secure  = secure_q;
   assign mode_rd = keep_q | {{(DW-1){1'b0}}, secure_q};

endmodule

// File: rtl/secure_access_gate.sv
module secure_access_gate
   import gate_pkg::*;
#(
   parameter int          AW        = 12,
   parameter int          DW        = 32,
   parameter int          NGRP      = 8,
   parameter int          SEL_W     = 4,
   parameter int          CTRL_CODE = 8,
   parameter int          ACC_OFS   = 0,
   parameter int          MODE_OFS  = 4,
   parameter logic [31:0] KEEP_MASK = 32'h0000_0042,
   parameter bit          REG_VIOL  = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [AW-1:0]   bus_addr,
   input  logic [DW-1:0]   bus_wdata,
   input  logic            bus_we,
   input  logic            bus_re,
   output logic [DW-1:0]   bus_rdata,
   input  logic [DW-1:0]   per_rdata,
   input  logic            sec_enter,
   output logic [NGRP-1:0] grant,
   output logic            fwd_we,
   output logic            secure_o,
   output logic            viol
);
   // Elaboration-time parameter checks
   if (NGRP > DW) begin : g_bad_w
      $error("access register wider than the data bus");
   end
   if (NGRP >= (1 << SEL_W) || CTRL_CODE < NGRP || CTRL_CODE >= (1 << SEL_W)) begin : g_bad_code
      $error("group codes and control page code do not fit the select field");
   end
   if (KEEP_MASK[0]) begin : g_bad_keep
      $error("keep mask must not include the secure flag");
   end
   if (SEL_W >= AW) begin : g_bad_aw
      $error("select field leaves no offset bits");
   end

   logic [NGRP-1:0] grp_hit;
   ctrl_hit_t       ctrl;
   logic [NGRP-1:0] acc_q;
   logic [DW-1:0]   mode_rd;
   logic [NGRP-1:0] allow;
   logic            access;
   logic            blocked;
   logic [DW-1:0]   rd;

   gate_decode #(
      .AW(AW), .SEL_W(SEL_W), .NGRP(NGRP),
      .CTRL_CODE(CTRL_CODE), .ACC_OFS(ACC_OFS), .MODE_OFS(MODE_OFS)
   ) u_dec (
      .addr    (bus_addr),
      .grp_hit (grp_hit),
      .ctrl    (ctrl)
   );

   gate_acc_reg #(.NGRP(NGRP)) u_acc (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (bus_we && ctrl.acc),
      .wdata  (bus_wdata[NGRP-1:0]),
      .secure (secure_o),
      .acc_q  (acc_q)
   );

   gate_mode_ctl #(.DW(DW), .KEEP_MASK(KEEP_MASK)) u_mode (
      .clk       (clk),
      .rst_n     (rst_n),
      .sec_enter (sec_enter),
      .wr        (bus_we && ctrl.mode),
      .wdata     (bus_wdata),
      .secure    (secure_o),
      .mode_rd   (mode_rd)
   );

   // Per-group permission and grant
   assign access  = bus_we || bus_re;
   assign allow   = secure_o ? {NGRP{1'b1}} : acc_q;
   assign grant   = access ? (grp_hit & allow) : '0;
   assign fwd_we  = bus_we && (|grant);
   assign blocked = access && (|(grp_hit & ~allow));

   // Read data: control page, then granted peripheral, else zero
   always_comb begin
      rd = '0;
      if (ctrl.acc)       rd[NGRP-1:0] = acc_q;
      else if (ctrl.mode) rd = mode_rd;
      else if (|grant)    rd = per_rdata;
   end
   assign bus_rdata = bus_re ? rd : '0;

   // Violation pulse: registered (default) or same-cycle variant
   if (REG_VIOL) begin : g_viol_reg
      logic viol_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) viol_q <= 1'b0;
         else        viol_q <= blocked;
      end
      assign viol = viol_q;
   end else begin : g_viol_comb
      assign viol = blocked;
   end

endmodule

// File: rtl/secure_access_gate_chk.sv
module secure_access_gate_chk #(
   parameter int NGRP     = 8,
   parameter int DW       = 32,
   parameter bit REG_VIOL = 1'b1
) (
   input logic            clk,
   input logic            rst_n,
   input logic            bus_we,
   input logic            bus_re,
   input logic [DW-1:0]   bus_wdata,
   input logic            sec_enter,
   input logic            secure_o,
   input logic [NGRP-1:0] grant,
   input logic            fwd_we,
   input logic            viol,
   input logic [NGRP-1:0] acc_q,
   input logic [NGRP-1:0] grp_hit,
   input logic            acc_wr
);
   // R2
   sec_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (secure_o && acc_wr) |=> (acc_q == $past(bus_wdata[NGRP-1:0])));

   // R4
   no_regain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!secure_o && acc_wr) |=> ((acc_q & ~$past(acc_q)) == '0));

   // R5
   blocked_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!secure_o && bus_we && (|(grp_hit & ~acc_q))) |-> !fwd_we);

   // R9
   enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sec_enter |=> secure_o);

   // R10
   grant_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|grant) |-> (bus_we || bus_re));

   // R12
   grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   if (REG_VIOL) begin : g_viol_chk
      // R7
      viol_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!secure_o && (bus_we || bus_re) && (|(grp_hit & ~acc_q))) |=> viol);
   end

endmodule

bind secure_access_gate secure_access_gate_chk #(
   .NGRP(NGRP), .DW(DW), .REG_VIOL(REG_VIOL)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_we    (bus_we),
   .bus_re    (bus_re),
   .bus_wdata (bus_wdata),
   .sec_enter (sec_enter),
   .secure_o  (secure_o),
   .grant     (grant),
   .fwd_we    (fwd_we),
   .viol      (viol),
   .acc_q     (acc_q),
   .grp_hit   (grp_hit),
   .acc_wr    (bus_we && ctrl.acc)
);

// File: tb/secure_access_gate_test.sv
module secure_access_gate_test;
   localparam int CLK_PER = 10;
   localparam logic [11:0] A_ACC  = 12'h800;
   localparam logic [11:0] A_MODE = 12'h804;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_we = 1'b0;
   logic        bus_re = 1'b0;
   logic [31:0] bus_rdata;
   logic [31:0] per_rdata;
   logic        sec_enter = 1'b0;
   logic [7:0]  grant;
   logic        fwd_we;
   logic        secure_o;
   logic        viol;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [31:0] r_data;
   logic [7:0]  s_grant;
   logic        s_fwd;
   logic        s_viol;

   always #(CLK_PER/2) clk = ~clk;

   secure_access_gate uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
      .per_rdata(per_rdata), .sec_enter(sec_enter), .grant(grant),
      .fwd_we(fwd_we), .secure_o(secure_o), .viol(viol)
   );

   // Peripheral stand-in: one data word per group
   logic [31:0] pmem [8];
   initial for (int g = 0; g < 8; g++) pmem[g] = 32'h0;
   always @(posedge clk) begin
      for (int g = 0; g < 8; g++)
         if (grant[g] && fwd_we) pmem[g] <= bus_wdata;
   end
   always_comb begin
      per_rdata = '0;
      for (int g = 0; g < 8; g++)
         if (grant[g]) per_rdata = per_rdata | pmem[g];
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      #1; s_grant = grant; s_fwd = fwd_we;
      @(posedge clk); #1;
      s_viol = viol;
      bus_we = 1'b0;
   endtask

   task automatic bus_rd(input logic [11:0] a);
      @(negedge clk);
      bus_addr = a; bus_re = 1'b1;
      #1; r_data = bus_rdata; s_grant = grant;
      @(posedge clk); #1;
      s_viol = viol;
      bus_re = 1'b0;
   endtask

   task automatic idle_viol(input string tag);
      @(posedge clk); #1;
      chk(tag, {31'b0, viol}, 32'h0);
   endtask

   task automatic pulse_enter();
      @(negedge clk); sec_enter = 1'b1;
      @(posedge clk); #1; sec_enter = 1'b0;
   endtask

   task automatic t_reset();
      bus_rd(A_ACC);  chk("R1 access reg after reset", r_data, 32'h0);
      bus_rd(A_MODE); chk("R1 mode reg after reset", r_data, 32'h1);
      chk("R1 secure after reset", {31'b0, secure_o}, 32'h1);
   endtask

   task automatic t_secure_store();
      bus_wr(A_ACC, 32'hFFFF_FFE5);
      bus_rd(A_ACC); chk("R2 secure store", r_data, 32'hE5);
      bus_wr(12'h100, 32'h1111_1111);
      chk("R9 secure grant io group (bit1 clear)", {24'b0, s_grant}, 32'h02);
      chk("R9 secure fwd", {31'b0, s_fwd}, 32'h1);
      bus_wr(12'h600, 32'h6666_6666);
   endtask

   task automatic t_exit();
      bus_wr(A_MODE, 32'hFFFF_FF42 & 32'hFFFF_FFFE);
      chk("R3 exit secure", {31'b0, secure_o}, 32'h0);
      bus_rd(A_MODE); chk("R3 mode keeps bits 1,6", r_data, 32'h42);
   endtask

   task automatic t_nonsec_acc();
      bus_wr(A_ACC, 32'hFF);
      chk("R8 acc write no viol", {31'b0, s_viol}, 32'h0);
      bus_rd(A_ACC); chk("R4 no set in non-secure", r_data, 32'hE5);
      chk("R8 acc read no viol", {31'b0, s_viol}, 32'h0);
      bus_wr(A_ACC, 32'hA5);
      bus_rd(A_ACC); chk("R4 clear bit6", r_data, 32'hA5);
   endtask

   task automatic t_blocked();
      bus_wr(12'h100, 32'hDEAD_BEEF);
      chk("R5 blocked grant", {24'b0, s_grant}, 32'h0);
      chk("R5 blocked fwd", {31'b0, s_fwd}, 32'h0);
      chk("R7 viol after blocked write", {31'b0, s_viol}, 32'h1);
      idle_viol("R7 viol one cycle");
      bus_rd(12'h100);
      chk("R5 blocked read zero", r_data, 32'h0);
      chk("R7 viol after blocked read", {31'b0, s_viol}, 32'h1);
   endtask

   task automatic t_allowed();
      bus_wr(12'h200, 32'h2222_2222);
      chk("R6 grant gpio", {24'b0, s_grant}, 32'h04);
      chk("R6 fwd", {31'b0, s_fwd}, 32'h1);
      chk("R6 no viol", {31'b0, s_viol}, 32'h0);
      bus_rd(12'h200); chk("R6 read back", r_data, 32'h2222_2222);
   endtask

   task automatic t_no_reenter();
      bus_wr(A_MODE, 32'h1);
      chk("R3 non-secure bit0 ignored", {31'b0, secure_o}, 32'h0);
      bus_rd(A_MODE); chk("R3 mode read", r_data, 32'h0);
   endtask

   task automatic t_revoke_enter();
      @(negedge clk); #1;
      chk("R10 quiet grants", {24'b0, grant}, 32'h0);
      pulse_enter();
      chk("R9 entry pulse", {31'b0, secure_o}, 32'h1);
      bus_rd(12'h600); chk("R10 revoked group intact", r_data, 32'h6666_6666);
      bus_rd(12'h100); chk("R5 blocked write left original", r_data, 32'h1111_1111);
      chk("R9 secure read grant", {24'b0, s_grant}, 32'h02);
   endtask

   task automatic t_race();
      bus_wr(A_MODE, 32'h0);
      @(negedge clk);
      bus_addr = A_ACC; bus_wdata = 32'hFF; bus_we = 1'b1; sec_enter = 1'b1;
      @(posedge clk); #1;
      bus_we = 1'b0; sec_enter = 1'b0;
      chk("R11 entry same cycle", {31'b0, secure_o}, 32'h1);
      bus_rd(A_ACC); chk("R11 write judged non-secure", r_data, 32'hA5);
      @(negedge clk);
      bus_addr = A_MODE; bus_wdata = 32'h0; bus_we = 1'b1; sec_enter = 1'b1;
      @(posedge clk); #1;
      bus_we = 1'b0; sec_enter = 1'b0;
      chk("R11 entry beats exit", {31'b0, secure_o}, 32'h1);
   endtask

   task automatic t_unmapped();
      bus_wr(A_MODE, 32'h0);
      bus_rd(12'hF00);
      chk("R12 unmapped read", r_data, 32'h0);
      chk("R12 unmapped grant", {24'b0, s_grant}, 32'h0);
      chk("R12 unmapped viol", {31'b0, s_viol}, 32'h0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      t_reset();
      t_secure_store();
      t_exit();
      t_nonsec_acc();
      t_blocked();
      t_allowed();
      t_no_reenter();
      t_revoke_enter();
      t_race();
      t_unmapped();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

endmodule